// File: doc/BRIEF.md
# Multi-Length Serial Frame Loader

This block takes a one-wire serial stream with its own bit clock and turns each load into register updates for a multiplexed display controller. It samples the data line on every falling edge of the serial clock, with the first bit being bit 0 of a command byte. The command byte decides how long the frame is. A header whose row-address field is all ones ends the frame after the byte itself. A header with both the blank and the set flag raised asks for 24 more configuration bits. Any other header is followed by 120 bits of column data for one display row.

The command byte and the 24-bit configuration word sit in registers that change only when the final bit of a frame has arrived. A row-data frame gives a one-cycle write strobe with a 5-bit row address and the 120-bit row, ready for an external display RAM. The configuration holds a column-order flag, which decides whether the first data bit goes to column 0 or to the last column, and a 6-bit contrast step that is brought out decoded. An active-low full reset returns both registers to their defaults. A second active-low reset clears only the bit position, so a host that was interrupted in the middle of a load can start again without losing any settings.

The serial clock and data are taken to be synchronous to the system clock `clk`. Each serial clock level lasts at least one `clk` cycle.

Top module: `serial_frame_loader`

## Requirements
- R1: When `rst_n` is low at a clock edge, `cmd_q` becomes 8'h00, `cfg_q` becomes 24'h020340 (config bits 14, 16, 17 and 25 set, at `cfg_q` indices 6, 8, 9 and 17), `contrast_step` reads 0 and `row_we` is low.
- R2: The data line is captured on the cycle that follows a falling edge of `ser_clk`. The first bit of a frame is command bit 0, and frame bit k has position k.
- R3: If command bits 3 to 7 are all 1, the frame ends after 8 bits and only `cmd_q` is updated. This is true even when bits 0 and 1 are also both 1.
- R4: If bits 0 and 1 are both 1 and bits 3 to 7 are not all 1, the frame is 32 bits long. `cfg_q[i]` takes frame bit i+8. `cfg_q[23:18]` (frame bits 26 to 31) is always stored as 0.
- R5: Any other header starts a 128-bit frame. When it ends, `row_we` is high for exactly one cycle, with `row_addr` equal to command bits 3 to 7 (bit 3 is the LSB).
- R6: With `cfg_q[8]` = 0, frame bit 8+j appears at `row_data[j]`. With `cfg_q[8]` = 1, it appears at `row_data[119-j]`.
- R7: `cmd_q`, `cfg_q` and the row outputs change only on the clock after the last bit of a frame. A frame that is only partly received changes none of them. Every completed frame stores its command byte in `cmd_q`.
- R8: A low `cnt_rst_n` clears the bit position only. `cmd_q` and `cfg_q` keep their values, and the next bit is treated as command bit 0.
- R9: `contrast_step` is `{cfg_q[10], cfg_q[11], cfg_q[12], cfg_q[13], cfg_q[14], cfg_q[15]}`, which places frame bit 18 at the MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low full reset |
| cnt_rst_n | input | 1 | Synchronous active-low reset of the bit position only |
| ser_clk | input | 1 | Serial bit clock; data taken on its falling edge |
| ser_data | input | 1 | Serial data line |
| cmd_q | output | 8 | Last completed command byte (bit i = frame bit i) |
| cfg_q | output | 24 | Configuration word (bit i = frame bit i+8) |
| contrast_step | output | 6 | Decoded contrast step |
| row_we | output | 1 | One-cycle write strobe for a completed row frame |
| row_addr | output | 5 | Row address of the write |
| row_data | output | 120 | Column data of the write |

## Verification
The frames used cover all three lengths. They include a header that carries both special codes together, which shows whether the all-ones address takes precedence. The configuration payload has its test bits set, so the forced zeros can be seen, and its contrast bits are asymmetric, so any reversal of the contrast bits is detected. Row frames are sent in both column orders with payloads that are not bit-palindromes, so a swapped order or a shift by one position is caught. Frames are also cut off by each of the two resets, to show that a partly received frame leaves the registers unchanged and that the next bit is treated as the start of a frame.

// File: rtl/sload_pkg.sv
// Shared sizes, defaults and types for the serial frame loader.
// Assumes the fixed header layout: flags in bits 0-2, row address in 3-7.
package sload_pkg;
    localparam int CMD_BITS   = 8;
    localparam int CFG_BITS   = 24;
    localparam int FRAME_BITS = 128;
    localparam int PAY_BITS   = FRAME_BITS - CMD_BITS;
    localparam int ADDR_BITS  = 5;
    localparam int ADDR_LO    = 3;
    localparam int CFG_FRAME_BITS = CMD_BITS + CFG_BITS;
    localparam int COL_ORDER_IDX  = 8;    // cfg index of the column-order flag
    localparam int CONTRAST_HI    = 10;   // cfg index of contrast MSB
    localparam int CONTRAST_BITS  = 6;
    localparam logic [CFG_BITS-1:0] CFG_RESET = 24'h020340;
    localparam logic [CFG_BITS-1:0] CFG_KEEP  = 24'h03FFFF;

    typedef enum logic [1:0] {FK_NONE, FK_CMD, FK_CFG, FK_ROW} frame_kind_e;
    typedef enum logic {BODY_CFG, BODY_ROW} body_e;
endpackage

// File: rtl/sload_edge.sv
// Detects falling edges of the serial clock.
// Assumes ser_clk is synchronous to clk and holds each level >= 1 cycle.
module sload_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_data,
    output logic take,
    output logic din
);
    logic sclk_q;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= ser_clk;
    end

    // A high-to-low change marks a bit to capture.
    always_comb begin
        take = sclk_q & ~ser_clk;
        din  = ser_data;
    end
endmodule

// File: rtl/sload_seq.sv
// Bit counter and header decoder: gathers the command byte, picks the frame
// length at the 8th bit and flags the final bit of each frame.
// Assumes take is a single-cycle strobe per serial bit.
module sload_seq
    import sload_pkg::*;
#(
    parameter int CMD_W     = CMD_BITS,
    parameter int CFG_LEN   = CFG_FRAME_BITS,
    parameter int FRAME_LEN = FRAME_BITS,
    parameter int A_LO      = ADDR_LO,
    localparam int CW = $clog2(FRAME_LEN),
    localparam int HW = $clog2(CMD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_rst_n,
    input  logic             take,
    input  logic             din,
    output frame_kind_e      kind,
    output logic [CMD_W-1:0] hdr_full,
    output logic [CW-1:0]    cnt_q,
    output logic             in_body
);
    logic [CMD_W-1:0] hdr_q;
    body_e            body_q;
    logic             at_hdr_end;

    // Decode the frame end from the position, header and body type.
    always_comb begin
        at_hdr_end = (cnt_q == CW'(CMD_W - 1));
        hdr_full   = hdr_q;
        if (at_hdr_end) hdr_full[CMD_W-1] = din;
        in_body    = (cnt_q >= CW'(CMD_W));
        kind       = FK_NONE;
        if (take && cnt_rst_n) begin
            if (at_hdr_end) begin
                if (&hdr_full[CMD_W-1:A_LO]) kind = FK_CMD;
            end else if (body_q == BODY_CFG && cnt_q == CW'(CFG_LEN - 1)) begin
                kind = FK_CFG;
            end else if (body_q == BODY_ROW && cnt_q == CW'(FRAME_LEN - 1)) begin
                kind = FK_ROW;
            end
        end
    end

    // Advance the bit position, capture header bits, latch the body type.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hdr_q  <= '0;
            body_q <= BODY_CFG;
        end else if (!cnt_rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            if (cnt_q < CW'(CMD_W)) hdr_q[cnt_q[HW-1:0]] <= din;
            if (kind != FK_NONE) cnt_q <= '0;
            else                 cnt_q <= cnt_q + CW'(1);
            if (at_hdr_end)
                body_q <= (hdr_full[0] & hdr_full[1]) ? BODY_CFG : BODY_ROW;
        end
    end
endmodule

// File: rtl/sload_shift.sv
// Payload shift register: bits after the header enter at the top, so the
// first payload bit sits at index 0 once a full row has arrived.
// Assumes shifting is enabled only for body bits.
module sload_shift #(
    parameter int PAY_W = sload_pkg::PAY_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [PAY_W-1:0] pay_next
);
    logic [PAY_W-1:0] pay_q;

    // View of the register including the bit being captured now.
    always_comb pay_next = {din, pay_q[PAY_W-1:1]};

    // Shift one body bit in per capture.
    always_ff @(posedge clk) begin
        if (!rst_n)        pay_q <= '0;
        else if (shift_en) pay_q <= pay_next;
    end
endmodule

// File: rtl/serial_frame_loader.sv
// Top of the serial frame loader: holds the command and configuration
// registers and issues one row write per completed data frame.
// Assumes the external RAM accepts a write in the cycle row_we is high.
module serial_frame_loader
    import sload_pkg::*;
#(
    parameter int CMD_W  = CMD_BITS,
    parameter int CFG_W  = CFG_BITS,
    parameter int PAY_W  = PAY_BITS,
    parameter int ADDR_W = ADDR_BITS,
    parameter int CON_W  = CONTRAST_BITS,
    localparam int CW = $clog2(CMD_W + PAY_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [CFG_W-1:0]  cfg_q,
    output logic [CON_W-1:0]  contrast_step,
    output logic              row_we,
    output logic [ADDR_W-1:0] row_addr,
    output logic [PAY_W-1:0]  row_data
);
    logic              take, din, in_body, frame_done;
    frame_kind_e       kind;
    logic [CMD_W-1:0]  hdr_full;
    logic [CW-1:0]     bit_cnt;
    logic [PAY_W-1:0]  pay_next, pay_rev, pay_ordered;

    sload_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .take(take), .din(din)
    );

    sload_seq #(
        .CMD_W(CMD_W), .CFG_LEN(CMD_W + CFG_W), .FRAME_LEN(CMD_W + PAY_W),
        .A_LO(ADDR_LO)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .cnt_rst_n(cnt_rst_n), .take(take),
        .din(din), .kind(kind), .hdr_full(hdr_full), .cnt_q(bit_cnt),
        .in_body(in_body)
    );

    sload_shift #(.PAY_W(PAY_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(take & in_body & cnt_rst_n),
        .din(din), .pay_next(pay_next)
    );

    // Mirror the payload for last-column-first ordering.
    for (genvar i = 0; i < PAY_W; i++) begin : g_rev
        assign pay_rev[i] = pay_next[PAY_W-1-i];
    end

    // Contrast step: lowest cfg index of the field is the MSB.
    for (genvar i = 0; i < CON_W; i++) begin : g_con
        assign contrast_step[CON_W-1-i] = cfg_q[CONTRAST_HI+i];
    end

    // Pick the column order from the stored flag.
    always_comb begin
        pay_ordered = cfg_q[COL_ORDER_IDX] ? pay_rev : pay_next;
        frame_done  = (kind != FK_NONE);
    end

    // Commit a completed frame to the registers and the row port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q    <= '0;
            cfg_q    <= CFG_RESET;
            row_we   <= 1'b0;
            row_addr <= '0;
            row_data <= '0;
        end else begin
            row_we <= 1'b0;
            if (frame_done) cmd_q <= hdr_full;
            if (kind == FK_CFG) cfg_q <= pay_next[PAY_W-1 -: CFG_W] & CFG_KEEP;
            if (kind == FK_ROW) begin
                row_we   <= 1'b1;
                row_addr <= hdr_full[ADDR_LO +: ADDR_W];
                row_data <= pay_ordered;
            end
        end
    end
endmodule

// File: rtl/sload_chk.sv
// Property checker for the serial frame loader, attached by bind.
// Assumes it observes the top's internal frame_done and bit_cnt.
module sload_chk #(
    parameter int CW = 7,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_rst_n,
    input logic          frame_done,
    input logic [CW-1:0] bit_cnt,
    input logic [7:0]    cmd_q,
    input logic [23:0]   cfg_q,
    input logic          row_we,
    input logic [AW-1:0] row_addr
);
    AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |=> !row_we); // R5
    AST_WE_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        row_we |-> row_addr == cmd_q[7:3]); // R5
    AST_TEST_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[23:18] == 6'd0); // R4
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(cmd_q)); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(cfg_q)); // R7
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rst_n |=> bit_cnt == '0); // R8
endmodule

bind serial_frame_loader sload_chk #(.CW(CW), .AW(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_rst_n(cnt_rst_n), .frame_done(frame_done),
    .bit_cnt(bit_cnt), .cmd_q(cmd_q), .cfg_q(cfg_q), .row_we(row_we),
    .row_addr(row_addr)
);

// File: tb/tb_serial_frame_loader.sv
module tb_serial_frame_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0, cnt_rst_n = 1'b1, ser_clk = 1'b0, ser_data = 1'b0;
    logic [7:0]   cmd_q;
    logic [23:0]  cfg_q;
    logic [5:0]   contrast_step;
    logic         row_we;
    logic [4:0]   row_addr;
    logic [119:0] row_data;
    int tests = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    serial_frame_loader dut (
        .clk(clk), .rst_n(rst_n), .cnt_rst_n(cnt_rst_n), .ser_clk(ser_clk),
        .ser_data(ser_data), .cmd_q(cmd_q), .cfg_q(cfg_q),
        .contrast_step(contrast_step), .row_we(row_we), .row_addr(row_addr),
        .row_data(row_data)
    );

    localparam logic [119:0] P1 = {60'h0123456789ABCDE, 60'hFEDCBA987654321};
    localparam logic [119:0] P2 = {8'h80, 104'h0, 8'hA5};
    localparam logic [119:0] P2_REV = {8'hA5, 104'h0, 8'h01};
    localparam int NV = 6;
    localparam logic [127:0] V_FRAME [NV] = '{
        {120'h0, 8'hF9}, {120'h0, 8'hFF}, {96'h0, 24'hFC0C11, 8'h03},
        {P1, 8'h2A}, {96'h0, 24'h000100, 8'h07}, {P2, 8'hC4}};
    localparam int           V_LEN [NV] = '{8, 8, 32, 128, 32, 128};
    localparam logic [7:0]   V_CMD [NV] = '{8'hF9, 8'hFF, 8'h03, 8'h2A, 8'h07, 8'hC4};
    localparam logic [23:0]  V_CFG [NV] = '{24'h020340, 24'h020340, 24'h000C11,
                                            24'h000C11, 24'h000100, 24'h000100};
    localparam logic [5:0]   V_CON [NV] = '{6'd0, 6'd0, 6'h30, 6'h30, 6'd0, 6'd0};
    localparam bit           V_WE  [NV] = '{0, 0, 0, 1, 0, 1};
    localparam logic [4:0]   V_ADDR[NV] = '{5'd0, 5'd0, 5'd0, 5'd5, 5'd0, 5'd24};
    localparam logic [119:0] V_DATA[NV] = '{120'h0, 120'h0, 120'h0, P1, 120'h0, P2_REV};

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser_data = b; ser_clk = 1'b1;
        @(negedge clk); ser_clk = 1'b0;
    endtask

    task automatic send_bits(input logic [127:0] f, input int n);
        for (int i = 0; i < n; i++) send_bit(f[i]);
    endtask

    initial begin
        logic [7:0] prev_cmd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cmd", cmd_q, 8'h00);
        chk("R1 reset cfg", cfg_q, 24'h020340);
        chk("R1 reset contrast", contrast_step, 6'd0);
        chk("R1 reset row_we", row_we, 1'b0);
        prev_cmd = 8'h00;

        // Vector walk: R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            send_bits(V_FRAME[v], V_LEN[v] - 1);
            @(negedge clk);
            chk($sformatf("R7 v%0d cmd held before last bit", v), cmd_q, prev_cmd);
            chk($sformatf("R7 v%0d no strobe before last bit", v), row_we, 1'b0);
            send_bit(V_FRAME[v][V_LEN[v]-1]);
            @(negedge clk);
            chk($sformatf("R3/R7 v%0d cmd", v), cmd_q, V_CMD[v]);
            chk($sformatf("R4 v%0d cfg", v), cfg_q, V_CFG[v]);
            chk($sformatf("R9 v%0d contrast", v), contrast_step, V_CON[v]);
            chk($sformatf("R5 v%0d row_we", v), row_we, V_WE[v]);
            if (V_WE[v]) begin
                chk($sformatf("R5 v%0d row_addr", v), row_addr, V_ADDR[v]);
                chk($sformatf("R6 v%0d row_data", v), row_data, V_DATA[v]);
                @(negedge clk);
                chk($sformatf("R5 v%0d strobe one cycle", v), row_we, 1'b0);
            end
            prev_cmd = V_CMD[v];
        end

        // R8: counter-only reset in the middle of a row frame
        send_bits({P1, 8'h10}, 40);
        @(negedge clk); cnt_rst_n = 1'b0;
        @(negedge clk); cnt_rst_n = 1'b1;
        @(negedge clk);
        chk("R8 cmd kept", cmd_q, 8'hC4);
        chk("R8 cfg kept", cfg_q, 24'h000100);
        send_bits({120'h0, 8'hF8}, 8);
        @(negedge clk);
        chk("R8 next bit is command bit 0", cmd_q, 8'hF8);
        chk("R8 no row write", row_we, 1'b0);

        // R1: full reset cutting a configuration frame
        send_bits({96'h0, 24'hFFFFFF, 8'h03}, 20);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mid-frame reset cmd", cmd_q, 8'h00);
        chk("R1 mid-frame reset cfg", cfg_q, 24'h020340);

        // R6: default order after reset is last-column-first
        send_bits({P2, 8'h08}, 128);
        @(negedge clk);
        chk("R5 post-reset row_we", row_we, 1'b1);
        chk("R5 post-reset row_addr", row_addr, 5'd1);
        chk("R6 post-reset reversed data", row_data, P2_REV);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule